// File: doc/BRIEF.md
# Asynchronous serial receiver with stop-bit check

This block is the receive side of an asynchronous serial port that keeps its settings in a small register bank. The port handles an 8-bit character frame and a 9-bit character frame. A receive flag tells software when a character has arrived, and an optional check raises a sticky flag when a frame ends without a valid stop level. A small transmit shifter sits beside the receiver and shares only the control register with it.

The receiver and the transmitter each count their own tick input. Each tick is one sixteenth of that side's bit time, so the two sides can run at different rates and at the same time. Software reaches the block through a single-cycle write strobe and a combinational read port with a 2-bit address. Address 0 is the control register, address 1 is the receive buffer for reads and the transmit load for writes, and address 2 is the option register.

Top module: `serial_rx_port`

## Requirements
- R1: With MODE = 01 (control bits 7:6, and FCHK = 0 so that bit 7 is the upper mode bit), a frame is one low start bit, 8 data bits sent LSB first, and a stop bit. Each bit's value is the majority of its samples at ticks 7, 8 and 9 counted from the start edge. The byte goes to the receive buffer at address 1, and the stop bit's value goes to RXB9 (control bit 2, output `rx_ninth`).
- R2: When the upper mode bit is 1 (MODE 10 or 11), a frame carries 9 data bits. The low 8 go to the buffer and the ninth goes to RXB9.
- R3: The control register at address 0 holds, from bit 7 down to bit 0: upper mode bit or FERR, lower mode bit, SPARE, RXEN, TXB9, RXB9, TXDONE, RXDONE. FCHK is bit 0 of the option register at address 2. When FCHK is 0, bit 7 reads and writes the upper mode bit. When FCHK is 1, bit 7 reads and writes FERR, and the upper mode bit keeps its value.
- R4: When FCHK = 1, a frame whose stop bit samples as 0 sets FERR (`frame_err`). When FCHK = 0, reception never changes FERR.
- R5: FERR is sticky. Later frames with a good stop bit leave it set, and changing FCHK leaves it set. Only a write to bit 7 while FCHK = 1, or a reset, changes it.
- R6: When FCHK = 1, RXDONE (`rx_irq`) rises at the stop-bit sample. When FCHK = 0, it rises at the sample of the last data bit, before the stop bit arrives.
- R7: A start bit that votes 1 at its centre is treated as noise. The receiver goes back to idle, no flag or buffer changes, and the next real frame is received correctly.
- R8: RXDONE is cleared only by a register write. A frame that completes while RXDONE is 1 is dropped, and the buffer and RXB9 keep their values.
- R9: No start bit is accepted while RXEN = 0. Clearing RXEN during a frame aborts that frame at the next bit boundary, with no flag or buffer update.
- R10: A write to address 1 while the transmitter is idle sends a low start bit, the 8 data bits LSB first, TXB9 when the upper mode bit is 1, and a high stop bit. Each bit lasts 16 transmit ticks. TXDONE (`tx_irq`) is set when the frame ends, and `txd` stays high while idle. Transmission runs at the same time as reception.
- R11: After reset, all three registers and the buffer read 0, both flags are 0, and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_tick | input | 1 | Receive oversampling tick, 16 per bit |
| tx_tick | input | 1 | Transmit oversampling tick, 16 per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| rx_data | output | 8 | Receive buffer |
| rx_ninth | output | 1 | RXB9 |
| rx_irq | output | 1 | RXDONE flag |
| tx_irq | output | 1 | TXDONE flag |
| frame_err | output | 1 | FERR flag |

## Verification
The bench probes RXDONE at the end of the last data bit, before the stop bit arrives. A design that ignores FCHK when timing the flag gives the wrong value there in one of the two settings. It sends bad-stop frames with the check on and with it off, and then sends good frames with the check on. A design that clears FERR on a good frame, or sets it while the check is off, is caught. It sends a frame while RXDONE is still set, with a stop value that differs from the one held in RXB9. A design that overwrites the held data shows a changed buffer or RXB9. A short low glitch, a frame cut off by clearing RXEN, and a full transmit frame sent during reception cover the cases where a design would latch a false start, finish an aborted frame, or let the two directions disturb each other.

// File: rtl/serial_rx_port.sv
module serial_rx_port #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_tick,
  input  logic       tx_tick,
  input  logic       rxd,
  output logic       txd,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] rx_data,
  output logic       rx_ninth,
  output logic       rx_irq,
  output logic       tx_irq,
  output logic       frame_err
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] S0 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] S1 = CW'(OSR/2);
  localparam logic [CW-1:0] S2 = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

  rx_state_t       rstate;
  logic [1:0]      rx_sync;
  logic            rx_prev;
  logic [CW-1:0]   rcnt;
  logic [3:0]      ridx;
  logic [8:0]      rsh;
  logic [1:0]      vs;
  logic            taken;
  logic            mode_h, mode_l, spare, rx_en, tx_b9, rx_b9, fchk;
  logic [7:0]      rbuf;

  logic            tbusy;
  logic [CW-1:0]   tcnt;
  logic [3:0]      tleft;
  logic [10:0]     tsh;

  wire rx_s      = rx_sync[1];
  wire rx_idle   = rstate == R_IDLE;
  wire nine      = mode_h;
  wire active    = mode_h | mode_l;
  wire vote      = (vs[0] & vs[1]) | (vs[0] & rx_s) | (vs[1] & rx_s);
  wire smp       = rx_tick && !rx_idle && rcnt == S2;
  wire bend      = rx_tick && !rx_idle && rcnt == LAST;
  wire [3:0] lastidx = nine ? 4'd8 : 4'd7;
  wire [8:0] nsh = {vote, rsh[8:1]};
  wire done_data = rstate == R_DATA && smp && ridx == lastidx && !fchk;
  wire done_stop = rstate == R_STOP && smp;
  wire [8:0] fr  = (rstate == R_STOP) ? rsh : nsh;
  wire load      = (done_data | (done_stop & fchk)) & ~rx_irq;
  wire wr_ctrl   = wr_en && addr == 2'd0;
  wire tx_load   = wr_en && addr == 2'd1 && !tbusy;
  wire tx_done   = tbusy && tx_tick && tcnt == LAST && tleft == 4'd1;

  assign rx_data  = rbuf;
  assign rx_ninth = rx_b9;
  assign txd      = ~tbusy | tsh[0];

  always_comb begin
    case (addr)
      2'd0:    rdata = {fchk ? frame_err : mode_h, mode_l, spare, rx_en, tx_b9, rx_b9, tx_irq, rx_irq};
      2'd1:    rdata = rbuf;
      2'd2:    rdata = {7'd0, fchk};
      default: rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rstate <= R_IDLE;
      rx_prev <= 1'b1;
      rcnt <= '0;
      ridx <= '0;
      rsh <= '0;
      vs <= '0;
      taken <= 1'b0;
      {mode_h, mode_l, spare, rx_en, tx_b9, rx_b9, tx_irq, rx_irq} <= '0;
      frame_err <= 1'b0;
      fchk <= 1'b0;
      rbuf <= '0;
    end else begin
      if (rx_tick) rx_prev <= rx_s;
      if (rx_tick && rcnt == S0) vs[0] <= rx_s;
      if (rx_tick && rcnt == S1) vs[1] <= rx_s;

      if (rx_idle) begin
        if (rx_tick && rx_en && active && rx_prev && !rx_s) begin
          rstate <= R_START;
          rcnt <= CW'(1);
          taken <= 1'b0;
        end
      end else begin
        if (rx_tick) rcnt <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
        if (bend && !rx_en) rstate <= R_IDLE;
        else begin
          case (rstate)
            R_START: begin
              if (smp && vote) rstate <= R_IDLE;
              else if (bend) begin
                rstate <= R_DATA;
                ridx <= '0;
              end
            end
            R_DATA: begin
              if (smp) rsh <= nsh;
              if (bend) begin
                if (ridx == lastidx) rstate <= R_STOP;
                else ridx <= ridx + 1'b1;
              end
            end
            R_STOP:  if (smp) rstate <= R_IDLE;
            default: rstate <= R_IDLE;
          endcase
        end
      end

      if (wr_ctrl) begin
        if (fchk) frame_err <= wdata[7];
        else      mode_h <= wdata[7];
        {mode_l, spare, rx_en, tx_b9, rx_b9, tx_irq, rx_irq} <= wdata[6:0];
      end
      if (wr_en && addr == 2'd2) fchk <= wdata[0];

      if (load) begin
        rbuf <= nine ? fr[7:0] : fr[8:1];
        rx_irq <= 1'b1;
        taken <= 1'b1;
        if (nine)      rx_b9 <= fr[8];
        else if (fchk) rx_b9 <= vote;
      end
      if (done_stop && !fchk && !nine && taken) rx_b9 <= vote;
      if (done_stop && fchk && !vote) frame_err <= 1'b1;
      if (tx_done) tx_irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbusy <= 1'b0;
      tcnt <= '0;
      tleft <= '0;
      tsh <= '1;
    end else if (tx_load) begin
      tbusy <= 1'b1;
      tcnt <= '0;
      tsh <= nine ? {1'b1, tx_b9, wdata, 1'b0} : {2'b11, wdata, 1'b0};
      tleft <= nine ? 4'd11 : 4'd10;
    end else if (tbusy && tx_tick) begin
      if (tcnt == LAST) begin
        tcnt <= '0;
        tsh <= {1'b1, tsh[10:1]};
        tleft <= tleft - 1'b1;
        if (tleft == 4'd1) tbusy <= 1'b0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

module serial_rx_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       fchk,
  input logic       frame_err,
  input logic       rx_irq,
  input logic [7:0] rx_data,
  input logic       rx_en,
  input logic       rx_idle,
  input logic       tbusy,
  input logic       txd
);
  AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !(wr_en && addr == 2'd0 && fchk)) |=> frame_err); // R5
  AST_FERR_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_err && !fchk) |=> !frame_err); // R4
  AST_RXDONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !(wr_en && addr == 2'd0)) |=> rx_irq); // R8
  AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> $stable(rx_data)); // R8
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_idle && !rx_en) |=> rx_idle); // R9
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tbusy |-> txd); // R10
endmodule

bind serial_rx_port serial_rx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .fchk(fchk),
  .frame_err(frame_err), .rx_irq(rx_irq), .rx_data(rx_data), .rx_en(rx_en),
  .rx_idle(rx_idle), .tbusy(tbusy), .txd(txd)
);

// File: tb/sim_serial_rx_port.sv
module sim_serial_rx_port;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, rxd, wr_en, txd, rx_ninth, rx_irq, tx_irq, frame_err;
  logic [1:0] addr;
  logic [7:0] wdata, rdata, rx_data;
  logic [1:0] rdiv = 2'd0, tdiv = 2'd0;
  logic rx_tick, tx_tick;
  int checks = 0, errors = 0;

  always @(posedge clk) begin
    rdiv <= rdiv + 2'd1;
    tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
  end
  assign rx_tick = rdiv == 2'd3;
  assign tx_tick = tdiv == 2'd2;

  serial_rx_port u0 (
    .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .tx_tick(tx_tick), .rxd(rxd), .txd(txd),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .rx_irq(rx_irq), .tx_irq(tx_irq), .frame_err(frame_err)
  );

  // mode[15:14] fchk[13] clear[12] data[11:3] stop[2] exp_b9[1] exp_ferr[0]
  localparam logic [15:0] VEC [8] = '{
    {2'b01, 1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b1, 9'h03C, 1'b0, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b0, 9'h0C3, 1'b1, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b0, 9'h155, 1'b1, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b1, 9'h0F0, 1'b1, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b0, 9'h10F, 1'b0, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b1, 9'h011, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b0, 9'h081, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic bitt(input logic b);
    @(negedge clk); rxd = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic [8:0] d, input logic stop, output logic mid);
    bitt(1'b0);
    for (int i = 0; i < 8; i++) bitt(d[i]);
    if (nine) bitt(d[8]);
    mid = rx_irq;
    bitt(stop);
    bitt(1'b1);
    bitt(1'b1);
  endtask

  task automatic cfg(input logic [1:0] mode, input logic fc, input logic clr);
    wr(2'd2, 8'h00);
    wr(2'd0, {mode, 1'b0, 1'b1, 4'b0000});
    wr(2'd2, {7'd0, fc});
    if (fc && clr) wr(2'd0, {1'b0, mode[0], 1'b0, 1'b1, 4'b0000});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic mid;
    logic [10:0] got;
    rst_n = 1'b0; rxd = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = 8'd0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk("R11 ctrl", {8'd0, v}, 16'h0);
    rd(2'd1, v); chk("R11 buffer", {8'd0, v}, 16'h0);
    rd(2'd2, v); chk("R11 option", {8'd0, v}, 16'h0);
    chk("R11 flags", {13'd0, rx_irq, tx_irq, frame_err}, 16'h0);
    chk("R11 txd", {15'd0, txd}, 16'h1);

    for (int n = 0; n < 8; n++) begin
      logic [15:0] e;
      e = VEC[n];
      cfg(e[15:14], e[13], e[12]);
      send(e[15], e[11:3], e[2], mid);
      chk("R6 rxdone before stop", {15'd0, mid}, {15'd0, !e[13]});
      chk(e[15] ? "R2 rxdone" : "R1 rxdone", {15'd0, rx_irq}, 16'h1);
      rd(2'd1, v);
      chk(e[15] ? "R2 buffer" : "R1 buffer", {8'd0, v}, {8'd0, e[10:3]});
      chk(e[15] ? "R2 ninth" : "R1 stop in ninth", {15'd0, rx_ninth}, {15'd0, e[1]});
      chk("R4 R5 ferr", {15'd0, frame_err}, {15'd0, e[0]});
    end

    cfg(2'b10, 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 bit7 is mode", {15'd0, v[7]}, 16'h1);
    wr(2'd2, 8'h01);
    rd(2'd0, v); chk("R3 bit7 is ferr", {15'd0, v[7]}, 16'h0);
    wr(2'd0, 8'h90);
    chk("R5 ferr write", {15'd0, frame_err}, 16'h1);
    wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R3 mode kept", {15'd0, v[7]}, 16'h1);
    chk("R5 ferr kept over option change", {15'd0, frame_err}, 16'h1);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h10);
    chk("R5 ferr cleared", {15'd0, frame_err}, 16'h0);
    wr(2'd2, 8'h00);
    rd(2'd0, v); chk("R3 mode untouched", {15'd0, v[7]}, 16'h1);

    cfg(2'b01, 1'b0, 1'b0);
    @(negedge clk); rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R7 glitch no flag", {15'd0, rx_irq}, 16'h0);
    send(1'b0, 9'h05A, 1'b1, mid);
    rd(2'd1, v); chk("R7 frame after glitch", {8'd0, v}, 16'h5A);

    send(1'b0, 9'h033, 1'b0, mid);
    rd(2'd1, v); chk("R8 buffer kept", {8'd0, v}, 16'h5A);
    chk("R8 ninth kept", {15'd0, rx_ninth}, 16'h1);
    chk("R8 rxdone held", {15'd0, rx_irq}, 16'h1);

    wr(2'd0, 8'h40);
    send(1'b0, 9'h044, 1'b1, mid);
    chk("R9 disabled no flag", {15'd0, rx_irq}, 16'h0);
    rd(2'd1, v); chk("R9 disabled buffer", {8'd0, v}, 16'h5A);
    wr(2'd0, 8'h50);
    fork
      send(1'b0, 9'h066, 1'b1, mid);
      begin repeat (256) @(negedge clk); wr(2'd0, 8'h40); end
    join
    chk("R9 abort no flag", {15'd0, rx_irq}, 16'h0);
    rd(2'd1, v); chk("R9 abort buffer", {8'd0, v}, 16'h5A);
    wr(2'd0, 8'h50);
    send(1'b0, 9'h077, 1'b1, mid);
    rd(2'd1, v); chk("R9 resume", {8'd0, v}, 16'h77);

    cfg(2'b11, 1'b0, 1'b0);
    wr(2'd0, 8'hD8);
    got = '0;
    fork
      begin
        wait (txd == 1'b0);
        repeat (24) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
          got[i] = txd;
          if (i < 10) repeat (48) @(negedge clk);
        end
      end
      wr(2'd1, 8'h96);
      send(1'b1, 9'h1C3, 1'b1, mid);
    join
    chk("R10 tx frame", {5'd0, got}, {5'd0, 1'b1, 1'b1, 8'h96, 1'b0});
    chk("R10 txdone", {15'd0, tx_irq}, 16'h1);
    chk("R10 txd idle", {15'd0, txd}, 16'h1);
    rd(2'd1, v); chk("R10 rx during tx", {8'd0, v}, 16'hC3);
    chk("R10 rx ninth during tx", {15'd0, rx_ninth}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule